// File: doc/BRIEF.md
# CSR Access Gate with Read-Modify-Write

This block stands between the instruction pipeline and a control/status register file. It accepts one register access per cycle: a 12-bit register address, the current privilege level, a debug flag, an operand and an operation kind. In the same cycle it does three things:

- It decides from the address and the privilege state whether the access is permitted.
- It reads the current register value through a combinational lookup port.
- It forms the merged value and writes it back in that cycle.

One cycle later it reports the old value, or raises a single-cycle illegal flag. In that case the register is left unchanged.

The block needs no table of what each register means. Privilege and write protection come from fixed address bits. User-visible counters are gated per counter index by two enable vectors, one from machine level and one from supervisor level. Performance monitor slots above the implemented count read as zero without touching the register file.

Top module: `csr_gate`

## Requirements
- R1: The privilege required by an address is its bits [9:8]. A non-debug request whose `req_priv` is numerically lower is illegal. A request with `req_debug` high skips this check.
- R2: An address with bits [11:10] equal to 2'b11 is read-only. Any request to it with a nonzero write mask is illegal. A request with a zero mask is a legal read.
- R3: `req_op` is encoded as follows:
  - 2'b00 is a read: mask is zero.
  - 2'b01 is a swap: mask is all ones and the new value is the operand.
  - 2'b10 is a set: mask is the operand and the new value is all ones.
  - 2'b11 is a clear: mask is the operand and the new value is zero.
- R4: A legal request with a nonzero mask writes `(old & ~mask) | (new & mask)` in its own cycle. A request with a zero mask performs no write.
- R5: Every request sampled with `req_valid` high produces `rsp_valid` exactly one cycle later. On a legal request `rsp_rdata` carries the value the register held before the write.
- R6: An illegal request raises `rsp_illegal` for that single response cycle with `rsp_rdata` zero, and the register keeps its value.
- R7: User counter addresses are 0xC00–0xC1F and 0xC80–0xC9F. For these, address bits [4:0] select an enable bit. Below machine level (`req_priv` != 2'b11), `mcnt_en` must have that bit set. At user level (2'b00), `scnt_en` must have it set as well. Otherwise the request is illegal.
- R8: Performance monitor slots are index 3 and above in the blocks 0xB00, 0xB80, 0xC00, 0xC80 and 0x320. A slot whose index is at or above 3+`HPM_COUNT` is unimplemented:
  - It reads as zero, regardless of the register file.
  - A write to it is legal and has no effect.
- R9: An address that the register file does not map (`rf_hit` low) and that is not covered by R8 is illegal.
- R10: The privilege encoding is 2'b00 user, 2'b01 supervisor and 2'b11 machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_priv | input | 2 | Current privilege level |
| req_debug | input | 1 | Debug access, bypasses the privilege check |
| req_op | input | 2 | Operation kind (read, swap, set, clear) |
| req_operand | input | XLEN | Source operand |
| mcnt_en | input | 32 | Machine-level counter enable vector |
| scnt_en | input | 32 | Supervisor-level counter enable vector |
| rf_addr | output | 12 | Register file lookup address |
| rf_hit | input | 1 | Register file maps `rf_addr` |
| rf_rdata | input | XLEN | Register file current value |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | XLEN | Merged write value |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | XLEN | Old register value, zero when illegal |
| rsp_illegal | output | 1 | Access was refused |

## Verification
The only state inside the block is the response stage, so a fault in the response register shows on `rsp_valid`, `rsp_rdata` or `rsp_illegal` one cycle after the request. A fault in the permission or merge logic shows up in two ways:

- A wrong merge or a stray write corrupts the register file at the request edge. The next read of that address returns the wrong data one cycle after the read is issued.
- A wrong permission decision flips `rsp_illegal` in the same response cycle.

For that reason the bench keeps a shadow copy of the register contents, reads modified registers back after every update, and compares the whole file at the end.

// File: rtl/csr_gate.sv
module csr_gate #(
  parameter int XLEN      = 32,
  parameter int HPM_COUNT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [11:0]     req_addr,
  input  logic [1:0]      req_priv,
  input  logic            req_debug,
  input  logic [1:0]      req_op,
  input  logic [XLEN-1:0] req_operand,
  input  logic [31:0]     mcnt_en,
  input  logic [31:0]     scnt_en,
  output logic [11:0]     rf_addr,
  input  logic            rf_hit,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [XLEN-1:0] rf_wdata,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_rdata,
  output logic            rsp_illegal
);
  localparam logic [1:0] OP_READ = 2'b00;
  localparam logic [1:0] OP_SWAP = 2'b01;
  localparam logic [1:0] OP_SET  = 2'b10;
  localparam logic [1:0] PRIV_S  = 2'b01;
  localparam logic [1:0] PRIV_M  = 2'b11;
  localparam logic [5:0] HPM_END = 6'(3 + HPM_COUNT);

  logic [XLEN-1:0] mask, newv, old;
  logic [6:0] blk;
  logic [4:0] idx;
  logic priv_fail, ro_fail, cnt_fail, nomap_fail, illegal;
  logic is_ucnt, hpm_blk, hpm_absent, mask_nz;

  always_comb begin
    case (req_op)
      OP_READ: begin mask = '0;          newv = '0;          end
      OP_SWAP: begin mask = '1;          newv = req_operand; end
      OP_SET:  begin mask = req_operand; newv = '1;          end
      default: begin mask = req_operand; newv = '0;          end
    endcase
  end

  assign blk     = req_addr[11:5];
  assign idx     = req_addr[4:0];
  assign mask_nz = |mask;

  assign is_ucnt    = (blk == 7'h60) || (blk == 7'h64);
  assign hpm_blk    = is_ucnt || (blk == 7'h58) || (blk == 7'h5C) || (blk == 7'h19);
  assign hpm_absent = hpm_blk && ({1'b0, idx} >= HPM_END);

  assign priv_fail  = !req_debug && (req_priv < req_addr[9:8]);
  assign ro_fail    = (req_addr[11:10] == 2'b11) && mask_nz;
  assign cnt_fail   = is_ucnt && (((req_priv < PRIV_M) && !mcnt_en[idx]) ||
                                  ((req_priv < PRIV_S) && !scnt_en[idx]));
  assign nomap_fail = !rf_hit && !hpm_absent;
  assign illegal    = priv_fail || ro_fail || cnt_fail || nomap_fail;

  assign old      = hpm_absent ? '0 : rf_rdata;
  assign rf_addr  = req_addr;
  assign rf_we    = req_valid && !illegal && mask_nz && !hpm_absent;
  assign rf_wdata = (old & ~mask) | (newv & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && illegal;
      rsp_rdata   <= (req_valid && !illegal) ? old : '0;
    end
  end
endmodule

// File: rtl/csr_gate_chk.sv
module csr_gate_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [11:0]     req_addr,
  input logic [1:0]      req_priv,
  input logic            req_debug,
  input logic [1:0]      req_op,
  input logic [XLEN-1:0] req_operand,
  input logic [31:0]     scnt_en,
  input logic [XLEN-1:0] rf_rdata,
  input logic            rf_we,
  input logic [XLEN-1:0] rf_wdata,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_rdata,
  input logic            rsp_illegal
);
  p_priv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_debug && (req_priv < req_addr[9:8]) |=> rsp_illegal);

  p_ro_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_addr[11:10] == 2'b11) && (req_op == 2'b01) |=> rsp_illegal);

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && (req_op == 2'b10) |-> ((rf_wdata & req_operand) == req_operand));

  p_clear_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && (req_op == 2'b11) |-> ((rf_wdata & req_operand) == '0));

  p_keep_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && (req_op != 2'b01) |-> (((rf_wdata ^ rf_rdata) & ~req_operand) == '0));

  p_no_write_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> req_valid && (req_op != 2'b00));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> rsp_valid && (rsp_rdata == '0));

  p_user_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ((req_addr[11:5] == 7'h60) || (req_addr[11:5] == 7'h64)) &&
    (req_priv == 2'b00) && !scnt_en[req_addr[4:0]] |=> rsp_illegal);
endmodule

bind csr_gate csr_gate_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_priv(req_priv), .req_debug(req_debug), .req_op(req_op),
  .req_operand(req_operand), .scnt_en(scnt_en), .rf_rdata(rf_rdata),
  .rf_we(rf_we), .rf_wdata(rf_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
);

// File: tb/csr_gate_tb.sv
module csr_gate_tb_top;
  localparam int XLEN = 32;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0] req_priv = 2'b11;
  logic req_debug = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [XLEN-1:0] req_operand = '0;
  logic [31:0] mcnt_en = '0, scnt_en = '0;
  logic [11:0] rf_addr;
  logic rf_hit, rf_we, rsp_valid, rsp_illegal;
  logic [XLEN-1:0] rf_rdata, rf_wdata, rsp_rdata;

  logic [11:0]     map  [NREG];
  logic [XLEN-1:0] mem  [NREG];
  logic [XLEN-1:0] shad [NREG];

  typedef struct {
    logic            ill;
    logic [XLEN-1:0] data;
    string           tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  csr_gate #(.XLEN(XLEN), .HPM_COUNT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .req_debug(req_debug), .req_op(req_op),
    .req_operand(req_operand), .mcnt_en(mcnt_en), .scnt_en(scnt_en),
    .rf_addr(rf_addr), .rf_hit(rf_hit), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_illegal(rsp_illegal)
  );

  function automatic int find(input logic [11:0] a);
    for (int i = 0; i < NREG; i++) if (map[i] == a) return i;
    return -1;
  endfunction

  always_comb begin
    int k;
    k = find(rf_addr);
    rf_hit   = (k >= 0);
    rf_rdata = (k >= 0) ? mem[k] : 32'hBAD0_BAD0;
  end

  always @(posedge clk) if (rf_we && find(rf_addr) >= 0) mem[find(rf_addr)] <= rf_wdata;

  task automatic issue(input logic [11:0] a, input logic [1:0] p, input logic dbg,
                       input logic [1:0] op, input logic [XLEN-1:0] opnd, input string tag);
    exp_t e;
    logic [XLEN-1:0] m, nv, old;
    logic ill, hz, ucnt, hblk;
    int k;
    logic [4:0] ix;
    ix = a[4:0];
    k = find(a);
    case (op)
      2'b00: begin m = '0;   nv = '0;   end
      2'b01: begin m = '1;   nv = opnd; end
      2'b10: begin m = opnd; nv = '1;   end
      default: begin m = opnd; nv = '0; end
    endcase
    ucnt = (a[11:5] == 7'h60) || (a[11:5] == 7'h64);
    hblk = ucnt || (a[11:5] == 7'h58) || (a[11:5] == 7'h5C) || (a[11:5] == 7'h19);
    hz   = hblk && (ix >= 5);
    ill  = 1'b0;
    if (!dbg && p < a[9:8]) ill = 1'b1;
    if (a[11:10] == 2'b11 && m != '0) ill = 1'b1;
    if (ucnt && p != 2'b11 && !mcnt_en[ix]) ill = 1'b1;
    if (ucnt && p == 2'b00 && !scnt_en[ix]) ill = 1'b1;
    if (k < 0 && !hz) ill = 1'b1;
    old = (hz || k < 0) ? '0 : shad[k];
    e.ill  = ill;
    e.data = ill ? '0 : old;
    e.tag  = tag;
    q.push_back(e);
    if (!ill && !hz && m != '0 && k >= 0) shad[k] = (old & ~m) | (nv & m);
    req_valid = 1'b1; req_addr = a; req_priv = p; req_debug = dbg;
    req_op = op; req_operand = opnd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected response: got valid=1 expected none");
      end else begin
        e = q.pop_front();
        if (rsp_illegal !== e.ill || rsp_rdata !== e.data) begin
          fails++;
          $display("FAIL %s: got ill=%0b data=%h expected ill=%0b data=%h",
                   e.tag, rsp_illegal, rsp_rdata, e.ill, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    map[0] = 12'h300; map[1] = 12'h340; map[2] = 12'h105; map[3] = 12'h040;
    map[4] = 12'hF14; map[5] = 12'hC00; map[6] = 12'hC02; map[7] = 12'hB03;
    mem[0] = 32'h0000_1800; mem[1] = 32'h0; mem[2] = 32'h100; mem[3] = 32'hA5;
    mem[4] = 32'h7; mem[5] = 32'h1234; mem[6] = 32'h55; mem[7] = 32'h99;
    for (int i = 0; i < NREG; i++) shad[i] = mem[i];
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_illegal !== 1'b0 || rsp_rdata !== '0) begin
      fails++;
      $display("FAIL R5 reset: got v=%0b i=%0b d=%h expected 0 0 0", rsp_valid, rsp_illegal, rsp_rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);

    issue(12'h300, 2'b11, 0, 2'b00, 32'h0, "R5 machine read");
    issue(12'h340, 2'b11, 0, 2'b01, 32'hDEAD_BEEF, "R3 swap");
    issue(12'h340, 2'b11, 0, 2'b10, 32'h0000_0F0F, "R3 set");
    issue(12'h340, 2'b11, 0, 2'b11, 32'hFFFF_0000, "R4 clear merge");
    issue(12'h340, 2'b11, 0, 2'b10, 32'h0, "R4 zero mask set");
    issue(12'h340, 2'b11, 0, 2'b00, 32'h0, "R4 readback");
    issue(12'h300, 2'b01, 0, 2'b00, 32'h0, "R1 supervisor on machine reg");
    issue(12'h300, 2'b01, 0, 2'b01, 32'h1111_1111, "R6 refused swap");
    issue(12'h300, 2'b11, 0, 2'b00, 32'h0, "R6 unchanged after refusal");
    issue(12'h300, 2'b01, 1, 2'b01, 32'h0000_0088, "R1 debug bypass");
    issue(12'h300, 2'b11, 0, 2'b00, 32'h0, "R1 debug write landed");
    issue(12'h105, 2'b00, 0, 2'b00, 32'h0, "R10 user on supervisor reg");
    issue(12'h105, 2'b01, 0, 2'b10, 32'h3, "R10 supervisor set");
    issue(12'h040, 2'b00, 0, 2'b11, 32'h0F, "R10 user clear");
    issue(12'hF14, 2'b11, 0, 2'b01, 32'h0, "R2 read-only swap");
    issue(12'hF14, 2'b11, 0, 2'b10, 32'h0, "R2 read-only zero-mask set");
    issue(12'hF14, 2'b11, 0, 2'b11, 32'h1, "R2 read-only clear");
    issue(12'hF14, 2'b11, 0, 2'b00, 32'h0, "R2 read-only unchanged");
    issue(12'hC00, 2'b00, 0, 2'b00, 32'h0, "R7 user counter both disabled");
    issue(12'hC00, 2'b11, 0, 2'b00, 32'h0, "R7 machine ignores enables");
    mcnt_en = 32'h1;
    issue(12'hC00, 2'b01, 0, 2'b00, 32'h0, "R7 supervisor with machine enable");
    issue(12'hC00, 2'b00, 0, 2'b00, 32'h0, "R7 user lacks supervisor enable");
    scnt_en = 32'h5;
    issue(12'hC00, 2'b00, 0, 2'b00, 32'h0, "R7 user fully enabled");
    issue(12'hC02, 2'b00, 0, 2'b00, 32'h0, "R7 index 2 lacks machine enable");
    mcnt_en = 32'h5;
    issue(12'hC02, 2'b00, 0, 2'b00, 32'h0, "R7 index 2 enabled");
    issue(12'hB03, 2'b11, 0, 2'b00, 32'h0, "R8 implemented slot");
    issue(12'hB05, 2'b11, 0, 2'b00, 32'h0, "R8 absent slot reads zero");
    issue(12'hB05, 2'b11, 0, 2'b01, 32'hFFFF_FFFF, "R8 absent slot write dropped");
    issue(12'h325, 2'b11, 0, 2'b00, 32'h0, "R8 absent event slot");
    issue(12'hC1F, 2'b11, 0, 2'b00, 32'h0, "R8 absent user slot");
    issue(12'hB04, 2'b11, 0, 2'b00, 32'h0, "R9 implemented slot not mapped");
    issue(12'h7C0, 2'b11, 0, 2'b00, 32'h0, "R9 unmapped address");
    issue(12'h7C0, 2'b11, 1, 2'b01, 32'h1, "R9 unmapped debug write");
    repeat (3) @(negedge clk);

    for (int i = 0; i < NREG; i++) begin
      checks++;
      if (mem[i] !== shad[i]) begin
        fails++;
        $display("FAIL R4 final contents %h: got %h expected %h", map[i], mem[i], shad[i]);
      end
    end
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R5 missing responses: got %0d pending expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule